// File: doc/BRIEF.md
# Crate Energy Sum Frame Packer

This block combines the energy reports of sixteen front-end digitizer streams inside one crate into a single uplink frame for the next level of the trigger. Each stream delivers one 32-bit word per 125 MHz cycle. That word holds two 16-bit energy sums, one for each of two consecutive 4 ns sample slots. Every cycle, the block adds the early-slot values of all enabled streams and the late-slot values of all enabled streams. The two crate totals are then packed into a fixed 64-bit frame together with a running frame counter and a CRC.

The block runs in a fixed-latency pipeline. The first stage registers the masked inputs. The second stage forms and clamps the two totals. The third stage assembles and registers the frame. A per-input enable vector, sampled in the same cycle as the data, leaves out streams that are noisy or absent. A frame is produced for every cycle in which the input word is marked valid, and for no other cycle.

Top module: `crate_sum_packer`

## Requirements
- R1: Input i occupies in_data[32i+31:32i]; its bits 15:0 are the early-slot sum and its bits 31:16 the late-slot sum. Frame bits 19:0 equal the total of the early-slot sums of the enabled inputs, and frame bits 39:20 equal the total of their late-slot sums.
- R2: An input whose in_enable bit is low adds zero to both totals, whatever its data; with every enable bit low both fields are zero.
- R3: A total is never truncated or wrapped: a value above 0xFFFFF is clamped to 0xFFFFF, and sixteen inputs all at 0xFFFF in both slots give exactly 0xFFFF0 in both fields.
- R4: Frame bits 47:40 carry a frame counter that is 0 in the first frame after reset, rises by one in each later frame, wraps from 255 to 0, and does not move in cycles without a frame.
- R5: Frame bits 63:48 carry a CRC-16 with polynomial 0x1021 and initial value 0xFFFF, with no reflection and no final XOR. It is taken over frame bits 47:0, starting with bit 47.
- R6: out_valid is high in exactly those cycles that come three clock edges after an edge at which in_valid was sampled high, and the frame shown in that cycle belongs to that input word.
- R7: While rst is high and after it falls, out_valid stays low until a new input word has passed through the pipeline. The frame counter starts again from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The input words are valid this cycle |
| in_enable | input | 16 | Per-input participation mask, bit i for input i |
| in_data | input | 512 | Sixteen 32-bit stream words, input i at bits 32i+31:32i |
| out_valid | output | 1 | out_frame holds a new frame |
| out_frame | output | 64 | Late-slot total, early-slot total, counter and CRC |

## Verification
The hardest conditions to reach from the ports are the counter wrap and the totals near full scale. The wrap needs more than 256 frames in one run, and the bench gets there by sending several hundred words with random gaps in in_valid. For full scale, every input is driven to 0xFFFF in both slots with all enables on, and again with all enables off. A reset in the middle of traffic, with frames still in the pipeline, shows that those frames are dropped and that the counter starts again from zero.

// File: rtl/csp_pkg.sv
package csp_pkg;

  localparam int CRC_W    = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;
  localparam int CRC_MAXD = 64;

  // MSB-first CRC over the low nbits of data, starting at bit nbits-1
  function automatic logic [CRC_W-1:0] crc_msb_first(input logic [CRC_MAXD-1:0] data,
                                                     input int nbits);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = CRC_INIT;
    for (int b = CRC_MAXD - 1; b >= 0; b--) begin
      if (b < nbits) begin
        fb = c[CRC_W-1] ^ data[b];
        c  = {c[CRC_W-2:0], 1'b0};
        if (fb) c = c ^ CRC_POLY;
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/csp_slot_sum.sv
module csp_slot_sum #(
  parameter int N_IN   = 16,
  parameter int SLOT_W = 16,
  parameter int SUM_W  = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_IN*SLOT_W-1:0]   vals,
  input  logic [N_IN-1:0]          enable,
  output logic [SUM_W-1:0]         total_q
);

  localparam int FULL_W = SLOT_W + $clog2(N_IN);

  logic [N_IN*SLOT_W-1:0] masked_q;
  logic [FULL_W-1:0]      raw_sum;
  logic [SUM_W-1:0]       clamped;

  // stage 1: masked operands
  always_ff @(posedge clk) begin
    if (rst) masked_q <= '0;
    else begin
      for (int i = 0; i < N_IN; i++)
        masked_q[i*SLOT_W +: SLOT_W] <= enable[i] ? vals[i*SLOT_W +: SLOT_W] : '0;
    end
  end

  always_comb begin
    raw_sum = '0;
    for (int i = 0; i < N_IN; i++)
      raw_sum = raw_sum + FULL_W'(masked_q[i*SLOT_W +: SLOT_W]);
  end

  generate
    if (FULL_W > SUM_W) begin : g_clamp
      always_comb begin
        if (raw_sum > FULL_W'({SUM_W{1'b1}})) clamped = '1;
        else                                  clamped = raw_sum[SUM_W-1:0];
      end
    end else begin : g_extend
      assign clamped = SUM_W'(raw_sum);
    end
  endgenerate

  // stage 2: clamped total
  always_ff @(posedge clk) begin
    if (rst) total_q <= '0;
    else     total_q <= clamped;
  end

endmodule

// File: rtl/csp_frame_builder.sv
module csp_frame_builder
  import csp_pkg::*;
#(
  parameter int SUM_W = 20,
  parameter int TS_W  = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                load,
  input  logic [SUM_W-1:0]                    early_sum,
  input  logic [SUM_W-1:0]                    late_sum,
  output logic                                frame_valid,
  output logic [CRC_W+TS_W+2*SUM_W-1:0]       frame
);

  localparam int PAY_W = TS_W + 2*SUM_W;

  logic [TS_W-1:0]  stamp_q;
  logic [PAY_W-1:0] payload;
  logic [CRC_W-1:0] check;

  assign payload = {stamp_q, late_sum, early_sum};
  assign check   = crc_msb_first(CRC_MAXD'(payload), PAY_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp_q     <= '0;
      frame_valid <= 1'b0;
      frame       <= '0;
    end else begin
      frame_valid <= load;
      if (load) begin
        frame   <= {check, payload};
        stamp_q <= stamp_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/crate_sum_packer.sv
module crate_sum_packer #(
  parameter int N_IN   = 16,
  parameter int SLOT_W = 16,
  parameter int N_SLOT = 2,
  parameter int SUM_W  = 20,
  parameter int TS_W   = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  input  logic [N_IN-1:0]                   in_enable,
  input  logic [N_IN*N_SLOT*SLOT_W-1:0]     in_data,
  output logic                              out_valid,
  output logic [16+TS_W+2*SUM_W-1:0]        out_frame
);

  localparam int WORD_W = N_SLOT * SLOT_W;

  logic [N_SLOT*SUM_W-1:0] totals;
  logic [1:0]              vld_pipe;

  generate
    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
      logic [N_IN*SLOT_W-1:0] slot_vals;
      for (genvar i = 0; i < N_IN; i++) begin : g_pick
        assign slot_vals[i*SLOT_W +: SLOT_W] = in_data[i*WORD_W + s*SLOT_W +: SLOT_W];
      end
      csp_slot_sum #(
        .N_IN  (N_IN),
        .SLOT_W(SLOT_W),
        .SUM_W (SUM_W)
      ) u_sum (
        .clk    (clk),
        .rst    (rst),
        .vals   (slot_vals),
        .enable (in_enable),
        .total_q(totals[s*SUM_W +: SUM_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) vld_pipe <= '0;
    else     vld_pipe <= {vld_pipe[0], in_valid};
  end

  csp_frame_builder #(
    .SUM_W(SUM_W),
    .TS_W (TS_W)
  ) u_frame (
    .clk        (clk),
    .rst        (rst),
    .load       (vld_pipe[1]),
    .early_sum  (totals[0 +: SUM_W]),
    .late_sum   (totals[SUM_W +: SUM_W]),
    .frame_valid(out_valid),
    .frame      (out_frame)
  );

endmodule

// File: rtl/csp_checker.sv
module csp_checker
  import csp_pkg::*;
#(
  parameter int N_IN  = 16,
  parameter int SUM_W = 20,
  parameter int TS_W  = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         in_valid,
  input logic [N_IN-1:0]              in_enable,
  input logic                         out_valid,
  input logic [16+TS_W+2*SUM_W-1:0]   out_frame
);

  localparam int PAY_W = TS_W + 2*SUM_W;

  logic [1:0]      run_cnt;
  logic            seen_q;
  logic [TS_W-1:0] last_ts_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt   <= '0;
      seen_q    <= 1'b0;
      last_ts_q <= '0;
    end else begin
      if (run_cnt != 2'd3) run_cnt <= run_cnt + 1'b1;
      if (out_valid) begin
        seen_q    <= 1'b1;
        last_ts_q <= out_frame[2*SUM_W +: TS_W];
      end
    end
  end

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    (run_cnt == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  assert_mask_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (run_cnt == 2'd3 && out_valid && $past(in_enable, 3) == '0)
      |-> (out_frame[2*SUM_W-1:0] == '0));

  assert_ts_first_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !seen_q) |-> (out_frame[2*SUM_W +: TS_W] == '0));

  assert_ts_step_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && seen_q) |-> (out_frame[2*SUM_W +: TS_W] == TS_W'(last_ts_q + 1'b1)));

  assert_crc_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_frame[PAY_W +: 16] ==
                   crc_msb_first(CRC_MAXD'(out_frame[PAY_W-1:0]), PAY_W)));

  assert_reset_idle_R7: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

bind crate_sum_packer csp_checker #(
  .N_IN (N_IN),
  .SUM_W(SUM_W),
  .TS_W (TS_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_enable(in_enable),
  .out_valid(out_valid),
  .out_frame(out_frame)
);

// File: tb/crate_sum_packer_bench.sv
module crate_sum_packer_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [15:0]  in_enable = '0;
  logic [511:0] in_data = '0;
  logic         out_valid;
  logic [63:0]  out_frame;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct { bit v; int s0; int s1; int ts; } exp_t;
  exp_t q[$];
  int   model_ts = 0;

  always #2.5 clk = ~clk;

  crate_sum_packer u_crate_sum_packer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_enable(in_enable),
    .in_data(in_data), .out_valid(out_valid), .out_frame(out_frame)
  );

  function automatic int ref_crc(longint unsigned payload);
    int c = 'hFFFF;
    for (int b = 47; b >= 0; b--) begin
      int fb = ((c >> 15) & 1) ^ int'((payload >> b) & 1);
      c = (c << 1) & 'hFFFF;
      if (fb != 0) c = c ^ 'h1021;
    end
    return c;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_front();
    exp_t e;
    longint unsigned pay;
    e = q.pop_front();
    chk(out_valid == e.v, "R6 out_valid timing", longint'(out_valid), longint'(e.v));
    if (e.v && out_valid) begin
      chk(int'(out_frame[19:0]) == e.s0, "R1/R2/R3 early total", longint'(out_frame[19:0]), e.s0);
      chk(int'(out_frame[39:20]) == e.s1, "R1/R2/R3 late total", longint'(out_frame[39:20]), e.s1);
      chk(int'(out_frame[47:40]) == e.ts, "R4 frame counter", longint'(out_frame[47:40]), e.ts);
      pay = {16'h0, 8'(e.ts), 20'(e.s1), 20'(e.s0)};
      chk(int'(out_frame[63:48]) == ref_crc(pay), "R5 check field",
          longint'(out_frame[63:48]), ref_crc(pay));
    end
  endtask

  // one clock: check the entry from three cycles ago, then drive and model new input
  task automatic cycle(bit v, logic [15:0] en, logic [511:0] d);
    exp_t e;
    int s0, s1;
    @(negedge clk);
    if (q.size() == 3) compare_front();
    in_valid  = v;
    in_enable = en;
    in_data   = d;
    s0 = 0; s1 = 0;
    for (int i = 0; i < 16; i++) begin
      if (en[i]) begin
        s0 += int'(d[32*i +: 16]);
        s1 += int'(d[32*i+16 +: 16]);
      end
    end
    if (s0 > 'hFFFFF) s0 = 'hFFFFF;
    if (s1 > 'hFFFFF) s1 = 'hFFFFF;
    e.v = v; e.s0 = s0; e.s1 = s1; e.ts = model_ts;
    if (v) model_ts = (model_ts + 1) % 256;
    q.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R7 idle in reset", longint'(out_valid), 0);
    end
    q.delete();
    model_ts = 0;
    rst = 1'b0;
  endtask

  function automatic logic [511:0] fill(int lo, int hi);
    logic [511:0] d;
    for (int i = 0; i < 16; i++) begin
      d[32*i +: 16]    = 16'(lo);
      d[32*i+16 +: 16] = 16'(hi);
    end
    return d;
  endfunction

  function automatic logic [511:0] rnd_data();
    logic [511:0] d;
    for (int i = 0; i < 16; i++) d[32*i +: 32] = $urandom;
    return d;
  endfunction

  initial begin
    do_reset();
    // R7: nothing emerges after reset with idle input
    for (int k = 0; k < 5; k++) cycle(1'b0, 16'hFFFF, '0);
    // R1: zero data and small uniform values
    cycle(1'b1, 16'hFFFF, '0);
    cycle(1'b1, 16'hFFFF, fill(1, 2));
    // R3: full scale in both slots, back to back
    for (int k = 0; k < 3; k++) cycle(1'b1, 16'hFFFF, fill('hFFFF, 'hFFFF));
    // R2: full scale with every input masked off
    cycle(1'b1, 16'h0000, fill('hFFFF, 'hFFFF));
    // R1: one input at a time
    for (int i = 0; i < 16; i++) begin
      logic [511:0] d = '0;
      d[32*i +: 32] = {16'(i + 100), 16'(i * 7 + 1)};
      cycle(1'b1, 16'hFFFF, d);
    end
    // R2: single input enabled among random data
    for (int i = 0; i < 16; i++) cycle(1'b1, 16'(1 << i), rnd_data());
    // R1 R2 R4 R6: random data, masks and gaps, long enough to wrap the counter
    for (int k = 0; k < 420; k++)
      cycle(($urandom % 4) != 0, 16'($urandom), rnd_data());
    // R7: reset with frames in flight, counter restarts
    cycle(1'b1, 16'hFFFF, rnd_data());
    cycle(1'b1, 16'hFFFF, rnd_data());
    do_reset();
    for (int k = 0; k < 6; k++) cycle(1'b1, 16'hFFFF, rnd_data());
    for (int k = 0; k < 4; k++) cycle(1'b0, 16'h0000, '0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule